// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block sits between a 32-bit host register bus and a downstream cycle engine. The host cannot address downstream configuration space or I/O-port space directly. It writes a target into one shared address register. It then reads or writes one of two data windows: one for configuration and one for I/O ports. Each window access starts exactly one downstream cycle of the matching kind. The byte lanes of that cycle are chosen from the size and the low offset bits of the window access. The host access stalls until the downstream side acknowledges, and the result comes back in the matching lanes.

Accesses to the address register complete on their own and start no downstream cycle. The same latched address serves both windows, so a window access always uses the value written last. Misaligned halfword or word accesses, and the reserved size code, are refused with an error flag and never reach the downstream side.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the address register reads 0x00000000 and both `h_ready` and `d_req` are low.
- R2: Offset 0x064 is the address register. Host writes update only the enabled lanes, and reads return its current value. An access to it completes with no downstream cycle.
- R3: An access to offset 0x068–0x06B starts a configuration cycle (`d_kind`=0). `d_addr` carries the register's bus field in bits 23:16, the device/function field in 15:8 and the register offset in 7:2. Bits 1:0 and 31:24 are zero.
- R4: An access to offset 0x06C–0x06F starts an I/O-port cycle (`d_kind`=1). `d_addr` is the low 16 bits of the address register, and bits 31:16 are zero.
- R5: Size codes are 0=byte, 1=halfword and 2=word. The active-high lane enable `d_be[i]` covers bits 8i+7:8i. A byte access enables lane offset[1:0], a halfword enables lanes 1:0 or 3:2 by offset[1], and a word enables all four lanes.
- R6: `d_wdata` equals the host write data with disabled lanes forced to zero. `d_write` follows the host direction. Read data returned to the host keeps only the enabled lanes, and the other lanes are zero.
- R7: While `d_req` is high and `d_ack` is low, `h_ready` stays low and all `d_*` request fields hold steady. The cycle after `d_ack` is sampled, `d_req` is low and `h_ready` is high for exactly one cycle. An acknowledge with no request pending is ignored.
- R8: A halfword at an odd offset, a word not on a 4-byte boundary, or size code 3 completes with `h_err` high, starts no downstream cycle and does not change the address register.
- R9: Both windows use the address last written to the address register, including after a partial-lane update.
- R10: Any other offset reads as zero, ignores writes and starts no downstream cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_sel | input | 1 | Host access request, held until `h_ready` |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_offs | input | 12 | Host byte offset |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| h_wdata | input | 32 | Host write data, lane-aligned |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| h_ready | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Access refused, valid with `h_ready` |
| d_req | output | 1 | Downstream cycle request |
| d_kind | output | 1 | 0 configuration, 1 I/O port |
| d_write | output | 1 | Downstream direction |
| d_addr | output | 32 | Downstream formatted address |
| d_be | output | 4 | Downstream lane enables |
| d_wdata | output | 32 | Downstream write data |
| d_ack | input | 1 | Downstream completion |
| d_rdata | input | 32 | Downstream read data, valid with `d_ack` |

## Verification
A wrong address register value shows up at the next window access, as a wrong `d_addr` in the first cycle of `d_req`. A wrong window decode shows up as a wrong `d_kind`, or as a request where none belongs, one cycle after the host access is taken. Lane errors are visible both on `d_be` and `d_wdata` at request time and in the masked `h_rdata` on the completion pulse. A stuck or early handshake state shows up within one cycle of the acknowledge, as a missing, lengthened or premature `h_ready`.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  localparam int DADDR_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_ADDR,
    TGT_CFG,
    TGT_IO
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DONE
  } st_e;

  // configuration address: bus/devfn/register with the dword select cleared
  function automatic logic [DADDR_W-1:0] fmt_cfg(input logic [31:0] a);
    return {8'h00, a[23:16], a[15:8], a[7:2], 2'b00};
  endfunction

  // port address: raw 16-bit port number
  function automatic logic [DADDR_W-1:0] fmt_io(input logic [31:0] a);
    return {16'h0000, a[15:0]};
  endfunction

endpackage

// File: rtl/cfgw_rst_sync.sv
module cfgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cfgw_decode.sv
module cfgw_decode
  import cfgw_pkg::*;
#(
  parameter int OFFS_W   = 12,
  parameter int LANES    = 4,
  parameter int ADDR_OFF = 'h064,
  parameter int CFG_OFF  = 'h068,
  parameter int IO_OFF   = 'h06C
) (
  input  logic [OFFS_W-1:0] offs,
  input  acc_size_e         size,
  output tgt_e              tgt,
  output logic [LANES-1:0]  be,
  output logic              misaligned
);

  localparam int LB = $clog2(LANES);
  localparam logic [OFFS_W-1:0] A_OFF = OFFS_W'(ADDR_OFF);
  localparam logic [OFFS_W-1:0] C_OFF = OFFS_W'(CFG_OFF);
  localparam logic [OFFS_W-1:0] I_OFF = OFFS_W'(IO_OFF);

  logic [OFFS_W-LB-1:0] word_idx;
  logic [LB-1:0]        lane_off;

  assign word_idx = offs[OFFS_W-1:LB];
  assign lane_off = offs[LB-1:0];

  always_comb begin
    if      (word_idx == A_OFF[OFFS_W-1:LB]) tgt = TGT_ADDR;
    else if (word_idx == C_OFF[OFFS_W-1:LB]) tgt = TGT_CFG;
    else if (word_idx == I_OFF[OFFS_W-1:LB]) tgt = TGT_IO;
    else                                     tgt = TGT_NONE;
  end

  always_comb begin
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lane_off[0];
      SZ_WORD: misaligned = (lane_off != '0);
      default: misaligned = 1'b1;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LB-1:0] LI = LB'(i);
    always_comb begin
      case (size)
        SZ_BYTE: be[i] = (lane_off == LI);
        SZ_HALF: be[i] = (lane_off[LB-1:1] == LI[LB-1:1]);
        SZ_WORD: be[i] = 1'b1;
        default: be[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cfgw_addr_reg.sv
module cfgw_addr_reg #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic       ce;
    logic [7:0] lane_q;
    logic [7:0] lane_n;

    assign ce = wr_en & be[i];

    always_comb begin
      lane_n = lane_q;
      if (ce) lane_n = wdata[8*i +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lane_q <= 8'h00;
      else if (ce) lane_q <= lane_n;
    end

    assign q[8*i +: 8] = lane_q;
  end

endmodule

// File: rtl/cfgw_cycle_fsm.sv
module cfgw_cycle_fsm
  import cfgw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_wr,
  input  tgt_e               tgt,
  input  logic [LANES-1:0]   be,
  input  logic               misaligned,
  input  logic [DATA_W-1:0]  h_wdata,
  input  logic [DATA_W-1:0]  addr_q,
  input  logic               d_ack,
  input  logic [DATA_W-1:0]  d_rdata,
  output logic               idle,
  output logic               h_ready,
  output logic               h_err,
  output logic [DATA_W-1:0]  h_rdata,
  output logic               d_req,
  output logic               d_kind,
  output logic               d_write,
  output logic [DADDR_W-1:0] d_addr,
  output logic [LANES-1:0]   d_be,
  output logic [DATA_W-1:0]  d_wdata
);

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] en);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{en[i]}};
    return m;
  endfunction

  st_e                st_q, st_n;
  logic               rdy_q, rdy_n;
  logic               err_q, err_n;
  logic [DATA_W-1:0]  rdata_q, rdata_n;
  logic               req_q, req_n;
  logic               kind_q, kind_n;
  logic               wr_q, wr_n;
  logic [DADDR_W-1:0] daddr_q, daddr_n;
  logic [LANES-1:0]   be_q, be_n;
  logic [DATA_W-1:0]  wd_q, wd_n;
  logic               launch;
  logic               rsp_ce;

  // next-state logic
  always_comb begin
    st_n    = st_q;
    rdy_n   = 1'b0;
    err_n   = 1'b0;
    rdata_n = rdata_q;
    req_n   = req_q;
    kind_n  = kind_q;
    wr_n    = wr_q;
    daddr_n = daddr_q;
    be_n    = be_q;
    wd_n    = wd_q;
    launch  = 1'b0;
    rsp_ce  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (h_sel) begin
          rsp_ce = 1'b1;
          if (misaligned) begin
            rdy_n   = 1'b1;
            err_n   = 1'b1;
            rdata_n = '0;
            st_n    = ST_DONE;
          end else begin
            unique case (tgt)
              TGT_ADDR: begin
                rdy_n   = 1'b1;
                rdata_n = h_wr ? '0 : addr_q;
                st_n    = ST_DONE;
              end
              TGT_CFG, TGT_IO: begin
                launch  = 1'b1;
                rsp_ce  = 1'b0;
                req_n   = 1'b1;
                kind_n  = (tgt == TGT_IO);
                wr_n    = h_wr;
                daddr_n = (tgt == TGT_IO) ? fmt_io(addr_q) : fmt_cfg(addr_q);
                be_n    = be;
                wd_n    = h_wr ? (h_wdata & lane_mask(be)) : '0;
                st_n    = ST_WAIT;
              end
              default: begin
                rdy_n   = 1'b1;
                rdata_n = '0;
                st_n    = ST_DONE;
              end
            endcase
          end
        end
      end
      ST_WAIT: begin
        if (d_ack) begin
          rsp_ce  = 1'b1;
          req_n   = 1'b0;
          rdy_n   = 1'b1;
          rdata_n = wr_q ? '0 : (d_rdata & lane_mask(be_q));
          st_n    = ST_DONE;
        end
      end
      default: begin
        st_n = ST_IDLE;
      end
    endcase
  end

  // state and handshake registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      rdy_q <= rdy_n;
      err_q <= err_n;
      req_q <= req_n;
    end
  end

  // request fields, loaded only when a cycle launches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= 1'b0;
      wr_q    <= 1'b0;
      daddr_q <= '0;
      be_q    <= '0;
      wd_q    <= '0;
    end else if (launch) begin
      kind_q  <= kind_n;
      wr_q    <= wr_n;
      daddr_q <= daddr_n;
      be_q    <= be_n;
      wd_q    <= wd_n;
    end
  end

  // response data, loaded only on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rsp_ce) rdata_q <= rdata_n;
  end

  assign idle    = (st_q == ST_IDLE);
  assign h_ready = rdy_q;
  assign h_err   = err_q;
  assign h_rdata = rdata_q;
  assign d_req   = req_q;
  assign d_kind  = kind_q;
  assign d_write = wr_q;
  assign d_addr  = daddr_q;
  assign d_be    = be_q;
  assign d_wdata = wd_q;

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgw_pkg::*;
#(
  parameter int OFFS_W   = 12,
  parameter int DATA_W   = 32,
  parameter int ADDR_OFF = 'h064,
  parameter int CFG_OFF  = 'h068,
  parameter int IO_OFF   = 'h06C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_wr,
  input  logic [OFFS_W-1:0] h_offs,
  input  logic [1:0]        h_size,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_ready,
  output logic              h_err,
  output logic              d_req,
  output logic              d_kind,
  output logic              d_write,
  output logic [31:0]       d_addr,
  output logic [DATA_W/8-1:0] d_be,
  output logic [DATA_W-1:0] d_wdata,
  input  logic              d_ack,
  input  logic [DATA_W-1:0] d_rdata
);

  localparam int LANES = DATA_W / 8;

  logic              rst_n_i;
  tgt_e              tgt;
  logic [LANES-1:0]  be;
  logic              mis;
  logic              idle;
  logic              areg_we;
  logic [DATA_W-1:0] addr_q;

  cfgw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  cfgw_decode #(
    .OFFS_W   (OFFS_W),
    .LANES    (LANES),
    .ADDR_OFF (ADDR_OFF),
    .CFG_OFF  (CFG_OFF),
    .IO_OFF   (IO_OFF)
  ) u_dec (
    .offs       (h_offs),
    .size       (acc_size_e'(h_size)),
    .tgt        (tgt),
    .be         (be),
    .misaligned (mis)
  );

  assign areg_we = idle & h_sel & h_wr & (tgt == TGT_ADDR) & ~mis;

  cfgw_addr_reg #(.DATA_W(DATA_W), .LANES(LANES)) u_areg (
    .clk   (clk),
    .rst_n (rst_n_i),
    .wr_en (areg_we),
    .be    (be),
    .wdata (h_wdata),
    .q     (addr_q)
  );

  cfgw_cycle_fsm #(.DATA_W(DATA_W), .LANES(LANES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .h_sel      (h_sel),
    .h_wr       (h_wr),
    .tgt        (tgt),
    .be         (be),
    .misaligned (mis),
    .h_wdata    (h_wdata),
    .addr_q     (addr_q),
    .d_ack      (d_ack),
    .d_rdata    (d_rdata),
    .idle       (idle),
    .h_ready    (h_ready),
    .h_err      (h_err),
    .h_rdata    (h_rdata),
    .d_req      (d_req),
    .d_kind     (d_kind),
    .d_write    (d_write),
    .d_addr     (d_addr),
    .d_be       (d_be),
    .d_wdata    (d_wdata)
  );

endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        h_ready,
  input logic        h_err,
  input logic        d_req,
  input logic        d_ack,
  input logic        d_kind,
  input logic        d_write,
  input logic [31:0] d_addr,
  input logic [3:0]  d_be,
  input logic [31:0] d_wdata
);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ack) |=> (d_req && $stable(d_addr) && $stable(d_be) &&
                           $stable(d_kind) && $stable(d_write) && $stable(d_wdata)));

  p_wait_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> !h_ready);

  p_ack_completes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_ack) |=> (h_ready && !d_req));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> !h_ready);

  p_err_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> (h_ready && !d_req));

  p_lane_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> ($countones(d_be) == 1 || d_be == 4'b0011 ||
               d_be == 4'b1100 || d_be == 4'b1111));

  p_cfg_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_kind) |-> (d_addr[1:0] == 2'b00 && d_addr[31:24] == 8'h00));

  p_io_format_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_kind) |-> (d_addr[31:16] == 16'h0000));

endmodule

bind cfg_window_bridge cfgw_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .h_ready (h_ready),
  .h_err   (h_err),
  .d_req   (d_req),
  .d_ack   (d_ack),
  .d_kind  (d_kind),
  .d_write (d_write),
  .d_addr  (d_addr),
  .d_be    (d_be),
  .d_wdata (d_wdata)
);

// File: tb/cfg_window_bridge_test.sv
`timescale 1ns/1ps
module cfg_window_bridge_test;

  typedef struct packed {
    logic        wr;
    logic [11:0] offs;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] devrd;
    logic [3:0]  dly;
    logic        x_req;
    logic        x_kind;
    logic [31:0] x_daddr;
    logic [3:0]  x_be;
    logic [31:0] x_dwdata;
    logic [31:0] x_rdata;
    logic        x_err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 12'h064, 2'd2, 32'h00ABCD5F, 32'h0,        4'd0, 1'b0, 1'b0, 32'h0,        4'h0, 32'h0,        32'h0,        1'b0},
    '{1'b0, 12'h064, 2'd2, 32'h0,        32'h0,        4'd0, 1'b0, 1'b0, 32'h0,        4'h0, 32'h0,        32'h00ABCD5F, 1'b0},
    '{1'b0, 12'h068, 2'd2, 32'h0,        32'hDEADBEEF, 4'd2, 1'b1, 1'b0, 32'h00ABCD5C, 4'hF, 32'h0,        32'hDEADBEEF, 1'b0},
    '{1'b0, 12'h06A, 2'd0, 32'h0,        32'h11223344, 4'd0, 1'b1, 1'b0, 32'h00ABCD5C, 4'h4, 32'h0,        32'h00220000, 1'b0},
    '{1'b1, 12'h06A, 2'd1, 32'hAAAA5555, 32'h0,        4'd1, 1'b1, 1'b0, 32'h00ABCD5C, 4'hC, 32'hAAAA0000, 32'h0,        1'b0},
    '{1'b1, 12'h06F, 2'd0, 32'h77112233, 32'h0,        4'd3, 1'b1, 1'b1, 32'h0000CD5F, 4'h8, 32'h77000000, 32'h0,        1'b0},
    '{1'b0, 12'h06C, 2'd1, 32'h0,        32'hFFFF1234, 4'd0, 1'b1, 1'b1, 32'h0000CD5F, 4'h3, 32'h0,        32'h00001234, 1'b0},
    '{1'b1, 12'h069, 2'd1, 32'h12345678, 32'h0,        4'd0, 1'b0, 1'b0, 32'h0,        4'h0, 32'h0,        32'h0,        1'b1},
    '{1'b0, 12'h06E, 2'd2, 32'h0,        32'h0,        4'd0, 1'b0, 1'b0, 32'h0,        4'h0, 32'h0,        32'h0,        1'b1},
    '{1'b0, 12'h070, 2'd2, 32'h0,        32'h0,        4'd0, 1'b0, 1'b0, 32'h0,        4'h0, 32'h0,        32'h0,        1'b0},
    '{1'b1, 12'h064, 2'd0, 32'h000000F0, 32'h0,        4'd0, 1'b0, 1'b0, 32'h0,        4'h0, 32'h0,        32'h0,        1'b0},
    '{1'b0, 12'h06C, 2'd2, 32'h0,        32'hCAFEF00D, 4'd1, 1'b1, 1'b1, 32'h0000CDF0, 4'hF, 32'h0,        32'hCAFEF00D, 1'b0},
    '{1'b0, 12'h06B, 2'd0, 32'h0,        32'h99887766, 4'd0, 1'b1, 1'b0, 32'h00ABCDF0, 4'h8, 32'h0,        32'h99000000, 1'b0},
    '{1'b1, 12'h064, 2'd3, 32'hFFFFFFFF, 32'h0,        4'd0, 1'b0, 1'b0, 32'h0,        4'h0, 32'h0,        32'h0,        1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        h_sel, h_wr;
  logic [11:0] h_offs;
  logic [1:0]  h_size;
  logic [31:0] h_wdata, h_rdata;
  logic        h_ready, h_err;
  logic        d_req, d_kind, d_write;
  logic [31:0] d_addr;
  logic [3:0]  d_be;
  logic [31:0] d_wdata;
  logic        d_ack;
  logic [31:0] d_rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic        saw_req, c_kind, c_write, got_err;
  logic [31:0] c_addr, c_wdata, got_rdata;
  logic [3:0]  c_be;

  cfg_window_bridge uut (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_offs(h_offs),
    .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
    .h_err(h_err), .d_req(d_req), .d_kind(d_kind), .d_write(d_write),
    .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_ack(d_ack), .d_rdata(d_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one host access with an emulated downstream responder
  task automatic host_access(input logic wr, input logic [11:0] offs,
                             input logic [1:0] size, input logic [31:0] wdata,
                             input logic [31:0] devrd, input int dly);
    @(negedge clk);
    h_sel = 1'b1; h_wr = wr; h_offs = offs; h_size = size; h_wdata = wdata;
    @(negedge clk);
    saw_req = d_req;
    if (d_req) begin
      c_kind = d_kind; c_write = d_write; c_addr = d_addr; c_be = d_be; c_wdata = d_wdata;
      for (int i = 0; i < dly; i++) begin
        check("R7", "ready low while waiting", {31'b0, h_ready}, 32'h0);
        check("R7", "addr held while waiting", d_addr, c_addr);
        @(negedge clk);
      end
      d_ack = 1'b1; d_rdata = devrd;
      @(negedge clk);
      d_ack = 1'b0; d_rdata = 32'h5A5A5A5A;
      check("R7", "request dropped after ack", {31'b0, d_req}, 32'h0);
    end
    got_rdata = h_rdata;
    got_err   = h_err;
    check("R7", "ready pulse on completion", {31'b0, h_ready}, 32'h1);
    h_sel = 1'b0; h_wr = 1'b0;
    @(negedge clk);
    check("R7", "ready lasts one cycle", {31'b0, h_ready}, 32'h0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    h_sel = 0; h_wr = 0; h_offs = 0; h_size = 0; h_wdata = 0;
    d_ack = 0; d_rdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during and after reset
    check("R1", "h_ready in reset", {31'b0, h_ready}, 32'h0);
    check("R1", "d_req in reset", {31'b0, d_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "d_req after reset", {31'b0, d_req}, 32'h0);
    host_access(1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 0);
    check("R1", "address register reset value", got_rdata, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      host_access(v.wr, v.offs, v.size, v.wdata, v.devrd, int'(v.dly));
      check(v.x_req ? "R3/R4" : "R2/R8/R10", "downstream cycle started",
            {31'b0, saw_req}, {31'b0, v.x_req});
      check("R8", "error flag", {31'b0, got_err}, {31'b0, v.x_err});
      check("R2/R6", "host read data", got_rdata, v.x_rdata);
      if (v.x_req && saw_req) begin
        check(v.x_kind ? "R4" : "R3", "cycle kind", {31'b0, c_kind}, {31'b0, v.x_kind});
        check("R9", "downstream address", c_addr, v.x_daddr);
        check("R5", "lane enables", {28'b0, c_be}, {28'b0, v.x_be});
        check("R6", "downstream direction", {31'b0, c_write}, {31'b0, v.wr});
        if (v.wr) check("R6", "downstream write data", c_wdata, v.x_dwdata);
      end
    end

    // R8: refused write left the address register alone
    host_access(1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 0);
    check("R8", "address kept after refused access", got_rdata, 32'h00ABCDF0);

    // R10: write to unmapped offset has no effect
    host_access(1'b1, 12'h074, 2'd2, 32'h11111111, 32'h0, 0);
    check("R10", "no cycle for unmapped write", {31'b0, saw_req}, 32'h0);
    host_access(1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 0);
    check("R10", "address unchanged by unmapped write", got_rdata, 32'h00ABCDF0);

    // R2: halfword update of upper lanes
    host_access(1'b1, 12'h066, 2'd1, 32'h00120000, 32'h0, 0);
    host_access(1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 0);
    check("R2", "upper halfword update", got_rdata, 32'h0012CDF0);

    // R7: stray acknowledge while idle is ignored
    @(negedge clk); d_ack = 1'b1;
    @(negedge clk); d_ack = 1'b0;
    check("R7", "stray ack gives no ready", {31'b0, h_ready}, 32'h0);
    @(negedge clk);
    check("R7", "stray ack gives no ready later", {31'b0, h_ready}, 32'h0);

    // R1: mid-run reset clears the address register
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    host_access(1'b0, 12'h064, 2'd2, 32'h0, 32'h0, 0);
    check("R1", "address cleared by reset", got_rdata, 32'h0);

    finish_run();
  end

endmodule